// File: doc/BRIEF.md
# Area-Decoded Control and Status Register File

This block sits on a simple word-wide register interface and serves as the control and status register file for a storage engine and a companion test-data generator. One shared address bus carries either a write (a write strobe with a 32-bit word) or a read (a one-cycle read request). The upper address bits pick one of three 256-byte areas. The first area holds write-only control parameters that drive the engine and the generator. The second area returns engine status. The third area returns generator status. One further word, above these areas, returns a fixed version number.

A write to the command word latches a 2-bit command code and raises a command request for exactly one cycle. The request is withheld while the engine reports busy. Reads go through two multiplexer levels. The first level picks a word inside each status area and is registered. The second level picks between areas and is also registered. Read data and its valid strobe therefore appear a fixed two cycles after the request.

Top module: `csr_area_file`

## Requirements
- R1: After reset every control output is zero, `cmd_req` is low and `rd_valid` is low.
- R2: The area is chosen by `reg_addr[11:8]`: 0 is the control area, 1 is engine status, 2 is generator status. A read of the control area, of an unused word in any area, or of any other area returns zero. A read of byte offset 0x800 returns the `VERSION` parameter. Address bits [1:0] are ignored.
- R3: For a request sampled at edge k, `rd_valid` is high for exactly one cycle, following edge k+2, and `rd_data` holds the word at that time. Back-to-back requests return back-to-back words in the order they were requested.
- R4: Every write replaces the full 32-bit word, and `reg_wr_be` has no effect. A write whose area is not 0 changes no control output and raises no command request.
- R5: Control words: 0x000 sets `start_name` from data[26:0], 0x004 sets `file_count` from data[26:0], 0x008 sets `fsize_sel` from data[2:0], and 0x014 sets `patt_sel` from data[2:0]. Higher data bits are dropped.
- R6: Word 0x00C unpacks into second = [4:0], minute = [10:5], hour = [15:11], day = [20:16], month = [24:21] and year = [31:25].
- R7: A write to 0x010 while the engine is not busy loads `cmd_code` from data[1:0] (00 format, 10 write file, 11 read file) and drives `cmd_req` high for the one cycle after the write edge.
- R8: A write to 0x010 while `eng_busy` is high leaves `cmd_code` unchanged and raises no `cmd_req`.
- R9: Engine area words, by byte offset: 0x100 = {29'b0, verify_fail, error, busy}; 0x104 total file capacity; 0x108 error type; 0x10C and 0x110 probe low and probe high; 0x114 directory capacity; 0x118 disk file size; 0x11C disk file count; 0x120 and 0x124 disk capacity low and high. Narrow fields are zero-extended.
- R10: Generator area words: 0x200 expected word; 0x204 read word; 0x208 and 0x20C failure address low and high; 0x210 failure file name; 0x214 and 0x218 transferred size low and high. Narrow fields are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 12 | Byte address, shared by reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write word |
| reg_wr_be | input | 4 | Byte enables (ignored) |
| reg_rd_req | input | 1 | Read request |
| reg_rd_data | output | 32 | Read word |
| reg_rd_valid | output | 1 | Read word valid |
| start_name | output | 27 | First file number |
| file_count | output | 27 | Number of files |
| fsize_sel | output | 3 | File size selector used when formatting |
| patt_sel | output | 3 | Test pattern selector |
| ts_second | output | 5 | Creation time, seconds |
| ts_minute | output | 6 | Creation time, minutes |
| ts_hour | output | 5 | Creation time, hours |
| ts_day | output | 5 | Creation date, day |
| ts_month | output | 4 | Creation date, month |
| ts_year | output | 7 | Creation date, year |
| cmd_code | output | 2 | Command code |
| cmd_req | output | 1 | One-cycle command request |
| eng_busy | input | 1 | Engine busy |
| eng_error | input | 1 | Engine error |
| tg_verify_fail | input | 1 | Generator data mismatch seen |
| eng_total_cap | input | 27 | Maximum file count |
| eng_err_type | input | 32 | Error detail |
| eng_probe_lo | input | 32 | Debug probe bits 31:0 |
| eng_probe_hi | input | 32 | Debug probe bits 63:32 |
| eng_dir_cap | input | 20 | Files per directory |
| eng_disk_fsize | input | 3 | File size found on disk |
| eng_disk_fnum | input | 27 | File count found on disk |
| eng_cap_lo | input | 32 | Disk sectors, low word |
| eng_cap_hi | input | 16 | Disk sectors, high bits |
| tg_exp_word | input | 32 | Expected word at first mismatch |
| tg_rd_word | input | 32 | Read word at first mismatch |
| tg_fail_addr_lo | input | 32 | Byte address of mismatch, low |
| tg_fail_addr_hi | input | 7 | Byte address of mismatch, high |
| tg_fail_name | input | 27 | File number of mismatch |
| tg_cur_size_lo | input | 32 | Bytes moved, low |
| tg_cur_size_hi | input | 24 | Bytes moved, high |

## Verification
A wrong word index or a wrong area select shows up as a wrong or nonzero `reg_rd_data` on the `reg_rd_valid` cycle two edges after the request. A missing or extra pipeline stage moves `reg_rd_valid` by one cycle, and the first read after reset exposes it. A bad write decode shows up one edge after the write, either as a changed control output or as a stray or missing `cmd_req` pulse. A busy gate that does not work shows up in the very next cycle as a pulse.

// File: rtl/csr_area_pkg.sv
package csr_area_pkg;
   localparam int unsigned WORD_IDX_W = 6;
   localparam int unsigned ENG_WORDS  = 10;
   localparam int unsigned TG_WORDS   = 7;

   localparam logic [WORD_IDX_W-1:0] CW_NAME  = 6'd0;
   localparam logic [WORD_IDX_W-1:0] CW_COUNT = 6'd1;
   localparam logic [WORD_IDX_W-1:0] CW_FSIZE = 6'd2;
   localparam logic [WORD_IDX_W-1:0] CW_STAMP = 6'd3;
   localparam logic [WORD_IDX_W-1:0] CW_CMD   = 6'd4;
   localparam logic [WORD_IDX_W-1:0] CW_PATT  = 6'd5;

   localparam int unsigned AREA_CTRL = 0;
   localparam int unsigned AREA_ENG  = 1;
   localparam int unsigned AREA_TG   = 2;
   localparam int unsigned AREA_VER  = 8;

   typedef enum logic [1:0] {
      CMD_FORMAT = 2'b00,
      CMD_RSVD   = 2'b01,
      CMD_WRFILE = 2'b10,
      CMD_RDFILE = 2'b11
   } cmd_e;

   typedef struct packed {
      logic [6:0] year;
      logic [3:0] month;
      logic [4:0] day;
      logic [4:0] hour;
      logic [5:0] minute;
      logic [4:0] second;
   } stamp_t;
endpackage

// File: rtl/csr_ctrl_bank.sv
module csr_ctrl_bank
   import csr_area_pkg::*;
#(
   parameter int unsigned NAME_W  = 27,
   parameter int unsigned FSIZE_W = 3,
   parameter int unsigned PATT_W  = 3,
   parameter int unsigned AREA_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AREA_W-1:0]     wr_area,
   input  logic [WORD_IDX_W-1:0] wr_word,
   input  logic [31:0]           wr_data,
   input  logic                  busy,
   output logic [NAME_W-1:0]     start_name,
   output logic [NAME_W-1:0]     file_count,
   output logic [FSIZE_W-1:0]    fsize_sel,
   output logic [PATT_W-1:0]     patt_sel,
   output stamp_t                stamp,
   output cmd_e                  cmd_code,
   output logic                  cmd_req
);
   logic in_ctrl;
   assign in_ctrl = wr_en && (wr_area == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_name <= '0;
         file_count <= '0;
         fsize_sel  <= '0;
         patt_sel   <= '0;
         stamp      <= '0;
         cmd_code   <= CMD_FORMAT;
         cmd_req    <= 1'b0;
      end else begin
         cmd_req <= 1'b0;
         if (in_ctrl) begin
            case (wr_word)
               CW_NAME:  start_name <= wr_data[NAME_W-1:0];
               CW_COUNT: file_count <= wr_data[NAME_W-1:0];
               CW_FSIZE: fsize_sel  <= wr_data[FSIZE_W-1:0];
               CW_PATT:  patt_sel   <= wr_data[PATT_W-1:0];
               CW_STAMP: stamp      <= stamp_t'(wr_data);
               CW_CMD: begin
                  if (!busy) begin
                     cmd_code <= cmd_e'(wr_data[1:0]);
                     cmd_req  <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   a_r8_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> !$past(busy));
   a_r7_req_from_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> $past(wr_en && wr_area == '0 && wr_word == CW_CMD));
   a_r4_other_area_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_area != '0) |=> ($stable(start_name) && $stable(file_count) &&
         $stable(fsize_sel) && $stable(patt_sel) && $stable(stamp) &&
         $stable(cmd_code) && !cmd_req));
endmodule

// File: rtl/csr_word_mux.sv
module csr_word_mux #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 6
) (
   input  logic [N-1:0][31:0] words,
   input  logic [IDX_W-1:0]   idx,
   output logic [31:0]        q
);
   generate
      if (N > (1 << IDX_W)) begin : g_bad
         $error("csr_word_mux: N exceeds index range");
      end
   endgenerate

   always_comb begin
      q = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (idx == IDX_W'(i)) q = words[i];
      end
   end
endmodule

// File: rtl/csr_read_pipe.sv
module csr_read_pipe
   import csr_area_pkg::*;
#(
   parameter int unsigned AREA_W  = 4,
   parameter logic [31:0] VERSION = 32'h0001_0200
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_req,
   input  logic [AREA_W-1:0]     rd_area,
   input  logic [WORD_IDX_W-1:0] rd_word,
   input  logic [31:0]           eng_word,
   input  logic [31:0]           tg_word,
   output logic [31:0]           rd_data,
   output logic                  rd_valid
);
   logic              req_q;
   logic [AREA_W-1:0] area_q;
   logic [31:0]       eng_q;
   logic [31:0]       tg_q;
   logic              ver_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         area_q <= '0;
         eng_q  <= '0;
         tg_q   <= '0;
         ver_q  <= 1'b0;
      end else begin
         req_q <= rd_req;
         if (rd_req) begin
            area_q <= rd_area;
            eng_q  <= eng_word;
            tg_q   <= tg_word;
            ver_q  <= (rd_word == '0);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_q;
         if (req_q) begin
            if (area_q == AREA_W'(AREA_ENG))               rd_data <= eng_q;
            else if (area_q == AREA_W'(AREA_TG))           rd_data <= tg_q;
            else if (area_q == AREA_W'(AREA_VER) && ver_q) rd_data <= VERSION;
            else                                           rd_data <= '0;
         end
      end
   end

   a_r3_valid_after_two: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> ##2 rd_valid);
   a_r2_ctrl_area_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_area == '0) |-> ##2 (rd_data == '0));
endmodule

// File: rtl/csr_area_file.sv
module csr_area_file
   import csr_area_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NAME_W    = 27,
   parameter int unsigned FSIZE_W   = 3,
   parameter int unsigned PATT_W    = 3,
   parameter int unsigned DIRCAP_W  = 20,
   parameter int unsigned CAPHI_W   = 16,
   parameter int unsigned FAILHI_W  = 7,
   parameter int unsigned CURHI_W   = 24,
   parameter logic [31:0] VERSION   = 32'h0001_0200
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr_en,
   input  logic [31:0]          reg_wr_data,
   input  logic [3:0]           reg_wr_be,
   input  logic                 reg_rd_req,
   output logic [31:0]          reg_rd_data,
   output logic                 reg_rd_valid,
   output logic [NAME_W-1:0]    start_name,
   output logic [NAME_W-1:0]    file_count,
   output logic [FSIZE_W-1:0]   fsize_sel,
   output logic [PATT_W-1:0]    patt_sel,
   output logic [4:0]           ts_second,
   output logic [5:0]           ts_minute,
   output logic [4:0]           ts_hour,
   output logic [4:0]           ts_day,
   output logic [3:0]           ts_month,
   output logic [6:0]           ts_year,
   output logic [1:0]           cmd_code,
   output logic                 cmd_req,
   input  logic                 eng_busy,
   input  logic                 eng_error,
   input  logic                 tg_verify_fail,
   input  logic [NAME_W-1:0]    eng_total_cap,
   input  logic [31:0]          eng_err_type,
   input  logic [31:0]          eng_probe_lo,
   input  logic [31:0]          eng_probe_hi,
   input  logic [DIRCAP_W-1:0]  eng_dir_cap,
   input  logic [FSIZE_W-1:0]   eng_disk_fsize,
   input  logic [NAME_W-1:0]    eng_disk_fnum,
   input  logic [31:0]          eng_cap_lo,
   input  logic [CAPHI_W-1:0]   eng_cap_hi,
   input  logic [31:0]          tg_exp_word,
   input  logic [31:0]          tg_rd_word,
   input  logic [31:0]          tg_fail_addr_lo,
   input  logic [FAILHI_W-1:0]  tg_fail_addr_hi,
   input  logic [NAME_W-1:0]    tg_fail_name,
   input  logic [31:0]          tg_cur_size_lo,
   input  logic [CURHI_W-1:0]   tg_cur_size_hi
);
   localparam int unsigned AREA_W = ADDR_W - 8;

   generate
      if (ADDR_W < 12) begin : g_addr_chk
         $error("csr_area_file: ADDR_W must reach the version word");
      end
      if (NAME_W > 32 || FSIZE_W > 32 || PATT_W > 32 || DIRCAP_W > 32 ||
          CAPHI_W > 32 || FAILHI_W > 32 || CURHI_W > 32) begin : g_width_chk
         $error("csr_area_file: field wider than a word");
      end
      if (FSIZE_W < 1 || PATT_W < 1 || NAME_W < 1) begin : g_min_chk
         $error("csr_area_file: empty control field");
      end
   endgenerate

   logic [AREA_W-1:0]     area;
   logic [WORD_IDX_W-1:0] word;
   logic                  addr_be_unused;
   assign area = reg_addr[ADDR_W-1:8];
   assign word = reg_addr[7:2];
   assign addr_be_unused = ^{reg_wr_be, reg_addr[1:0]};

   stamp_t stamp;
   cmd_e   code;

   csr_ctrl_bank #(
      .NAME_W (NAME_W),
      .FSIZE_W(FSIZE_W),
      .PATT_W (PATT_W),
      .AREA_W (AREA_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_area   (area),
      .wr_word   (word),
      .wr_data   (reg_wr_data),
      .busy      (eng_busy),
      .start_name(start_name),
      .file_count(file_count),
      .fsize_sel (fsize_sel),
      .patt_sel  (patt_sel),
      .stamp     (stamp),
      .cmd_code  (code),
      .cmd_req   (cmd_req)
   );

   assign cmd_code  = code;
   assign ts_second = stamp.second;
   assign ts_minute = stamp.minute;
   assign ts_hour   = stamp.hour;
   assign ts_day    = stamp.day;
   assign ts_month  = stamp.month;
   assign ts_year   = stamp.year;

   logic [ENG_WORDS-1:0][31:0] eng_words;
   logic [TG_WORDS-1:0][31:0]  tg_words;

   assign eng_words[0] = {29'd0, tg_verify_fail, eng_error, eng_busy};
   assign eng_words[1] = 32'(eng_total_cap);
   assign eng_words[2] = eng_err_type;
   assign eng_words[3] = eng_probe_lo;
   assign eng_words[4] = eng_probe_hi;
   assign eng_words[5] = 32'(eng_dir_cap);
   assign eng_words[6] = 32'(eng_disk_fsize);
   assign eng_words[7] = 32'(eng_disk_fnum);
   assign eng_words[8] = eng_cap_lo;
   assign eng_words[9] = 32'(eng_cap_hi);

   assign tg_words[0] = tg_exp_word;
   assign tg_words[1] = tg_rd_word;
   assign tg_words[2] = tg_fail_addr_lo;
   assign tg_words[3] = 32'(tg_fail_addr_hi);
   assign tg_words[4] = 32'(tg_fail_name);
   assign tg_words[5] = tg_cur_size_lo;
   assign tg_words[6] = 32'(tg_cur_size_hi);

   logic [31:0] eng_sel;
   logic [31:0] tg_sel;

   csr_word_mux #(.N(ENG_WORDS), .IDX_W(WORD_IDX_W)) u_eng_mux (
      .words(eng_words), .idx(word), .q(eng_sel));
   csr_word_mux #(.N(TG_WORDS), .IDX_W(WORD_IDX_W)) u_tg_mux (
      .words(tg_words), .idx(word), .q(tg_sel));

   csr_read_pipe #(.AREA_W(AREA_W), .VERSION(VERSION)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_req  (reg_rd_req),
      .rd_area (area),
      .rd_word (word),
      .eng_word(eng_sel),
      .tg_word (tg_sel),
      .rd_data (reg_rd_data),
      .rd_valid(reg_rd_valid)
   );

   a_r3_no_orphan_valid: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_valid |-> $past(reg_rd_req, 2));
   a_r7_req_single_per_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !$past(reg_wr_en, 2)) |=> !cmd_req || $past(reg_wr_en));
endmodule

// File: tb/tb_csr_area_file.sv
module tb_csr_area_file;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [3:0]  reg_wr_be = '0;
   logic        reg_rd_req = 1'b0;
   logic [31:0] reg_rd_data;
   logic        reg_rd_valid;
   logic [26:0] start_name, file_count;
   logic [2:0]  fsize_sel, patt_sel;
   logic [4:0]  ts_second, ts_hour, ts_day;
   logic [5:0]  ts_minute;
   logic [3:0]  ts_month;
   logic [6:0]  ts_year;
   logic [1:0]  cmd_code;
   logic        cmd_req;
   logic        eng_busy = 1'b0;

   localparam logic [31:0] VER = 32'h0001_0200;

   always #10 clk = ~clk;

   csr_area_file #(.VERSION(VER)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
      .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid),
      .start_name(start_name), .file_count(file_count), .fsize_sel(fsize_sel),
      .patt_sel(patt_sel), .ts_second(ts_second), .ts_minute(ts_minute),
      .ts_hour(ts_hour), .ts_day(ts_day), .ts_month(ts_month), .ts_year(ts_year),
      .cmd_code(cmd_code), .cmd_req(cmd_req),
      .eng_busy(eng_busy), .eng_error(1'b1), .tg_verify_fail(1'b1),
      .eng_total_cap(27'h123_4567), .eng_err_type(32'hDEAD_BEEF),
      .eng_probe_lo(32'h0102_0304), .eng_probe_hi(32'hA5A5_5A5A),
      .eng_dir_cap(20'hF_EDCB), .eng_disk_fsize(3'd5), .eng_disk_fnum(27'h7AB_CDEF),
      .eng_cap_lo(32'h8765_4321), .eng_cap_hi(16'hBEEF),
      .tg_exp_word(32'h1111_2222), .tg_rd_word(32'h3333_4444),
      .tg_fail_addr_lo(32'h5555_6666), .tg_fail_addr_hi(7'h7F),
      .tg_fail_name(27'h000_0ABC), .tg_cur_size_lo(32'h9999_AAAA),
      .tg_cur_size_hi(24'hC0_FFEE)
   );

   int n_run = 0;
   int n_fail = 0;

   localparam int NV = 26;
   localparam logic [43:0] VEC [0:NV-1] = '{
      {12'h100, 32'h0000_0006}, {12'h104, 32'h0123_4567}, {12'h108, 32'hDEAD_BEEF},
      {12'h10C, 32'h0102_0304}, {12'h110, 32'hA5A5_5A5A}, {12'h114, 32'h000F_EDCB},
      {12'h118, 32'h0000_0005}, {12'h11C, 32'h07AB_CDEF}, {12'h120, 32'h8765_4321},
      {12'h124, 32'h0000_BEEF}, {12'h128, 32'h0000_0000}, {12'h1FC, 32'h0000_0000},
      {12'h200, 32'h1111_2222}, {12'h204, 32'h3333_4444}, {12'h208, 32'h5555_6666},
      {12'h20C, 32'h0000_007F}, {12'h210, 32'h0000_0ABC}, {12'h214, 32'h9999_AAAA},
      {12'h218, 32'h00C0_FFEE}, {12'h21C, 32'h0000_0000}, {12'h300, 32'h0000_0000},
      {12'h800, VER},           {12'h804, 32'h0000_0000}, {12'h000, 32'h0000_0000},
      {12'h014, 32'h0000_0000}, {12'h103, 32'h0000_0006}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_addr = a; reg_wr_data = d; reg_wr_be = be; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a; reg_rd_req = 1'b1;
      @(negedge clk);
      reg_rd_req = 1'b0;
      chk("R3 valid not early", {31'd0, reg_rd_valid}, 32'd0);
      @(negedge clk);
      chk("R3 valid at two cycles", {31'd0, reg_rd_valid}, 32'd1);
      chk(tag, reg_rd_data, exp);
      @(negedge clk);
      chk("R3 valid one cycle", {31'd0, reg_rd_valid}, 32'd0);
   endtask

   task automatic ctrl_snapshot(input string tag, input logic [26:0] nm, input logic [26:0] cnt,
                                input logic [2:0] fs, input logic [2:0] pt, input logic [1:0] cc);
      chk({tag, " name"}, 32'(start_name), 32'(nm));
      chk({tag, " count"}, 32'(file_count), 32'(cnt));
      chk({tag, " fsize"}, 32'(fsize_sel), 32'(fs));
      chk({tag, " patt"}, 32'(patt_sel), 32'(pt));
      chk({tag, " code"}, 32'(cmd_code), 32'(cc));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] stamp_word;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      ctrl_snapshot("R1", '0, '0, '0, '0, '0);
      chk("R1 stamp", {ts_year, ts_month, ts_day, ts_hour, ts_minute, ts_second}, 32'd0);
      chk("R1 cmd_req", {31'd0, cmd_req}, 32'd0);
      chk("R1 rd_valid", {31'd0, reg_rd_valid}, 32'd0);

      // R5 and R4: full-word writes with byte enables off, high bits dropped
      wr(12'h000, 32'hFFFF_FFFF, 4'h0);
      chk("R4 R5 name, be ignored", 32'(start_name), 32'h07FF_FFFF);
      wr(12'h004, 32'h0ABC_DEF1, 4'h1);
      chk("R5 count", 32'(file_count), 32'h02BC_DEF1);
      wr(12'h008, 32'h0000_000F, 4'hF);
      chk("R5 fsize", 32'(fsize_sel), 32'd7);
      wr(12'h014, 32'hFFFF_FFFD, 4'h2);
      chk("R5 patt", 32'(patt_sel), 32'd5);

      // R6 date/time packing
      stamp_word = {7'd45, 4'd7, 5'd5, 5'd23, 6'd59, 5'd29};
      wr(12'h00C, stamp_word, 4'hF);
      chk("R6 second", 32'(ts_second), 32'd29);
      chk("R6 minute", 32'(ts_minute), 32'd59);
      chk("R6 hour", 32'(ts_hour), 32'd23);
      chk("R6 day", 32'(ts_day), 32'd5);
      chk("R6 month", 32'(ts_month), 32'd7);
      chk("R6 year", 32'(ts_year), 32'd45);

      // R7 command pulses
      wr(12'h010, 32'h0000_0002, 4'hF);
      chk("R7 write-file pulse", {31'd0, cmd_req}, 32'd1);
      chk("R7 write-file code", 32'(cmd_code), 32'd2);
      @(negedge clk);
      chk("R7 pulse one cycle", {31'd0, cmd_req}, 32'd0);
      wr(12'h010, 32'hFFFF_FFF3, 4'h0);
      chk("R7 read-file pulse", {31'd0, cmd_req}, 32'd1);
      chk("R7 read-file code", 32'(cmd_code), 32'd3);
      wr(12'h010, 32'h0000_0000, 4'hF);
      chk("R7 format pulse", {31'd0, cmd_req}, 32'd1);
      chk("R7 format code", 32'(cmd_code), 32'd0);

      // R4 writes to read-only areas and version word have no effect
      wr(12'h100, 32'hFFFF_FFFF, 4'hF);
      chk("R4 no pulse 0x100", {31'd0, cmd_req}, 32'd0);
      wr(12'h210, 32'hFFFF_FFFF, 4'hF);
      wr(12'h810, 32'hFFFF_FFFF, 4'hF);
      chk("R4 no pulse 0x810", {31'd0, cmd_req}, 32'd0);
      ctrl_snapshot("R4", 27'h7FF_FFFF, 27'h2BC_DEF1, 3'd7, 3'd5, 2'd0);
      chk("R4 stamp kept", {ts_year, ts_month, ts_day, ts_hour, ts_minute, ts_second}, stamp_word);

      // R8 busy blocks command
      eng_busy = 1'b1;
      wr(12'h010, 32'h0000_0003, 4'hF);
      chk("R8 no pulse while busy", {31'd0, cmd_req}, 32'd0);
      chk("R8 code kept", 32'(cmd_code), 32'd0);
      @(negedge clk);
      chk("R8 still no pulse", {31'd0, cmd_req}, 32'd0);
      rd(12'h100, 32'h0000_0007, "R9 status with busy");
      eng_busy = 1'b0;

      // Vector table walk: R2, R9, R10
      for (int i = 0; i < NV; i++) begin
         logic [11:0] a;
         string tag;
         a = VEC[i][43:32];
         if (a[11:8] == 4'h1) tag = $sformatf("R9 read %h", a);
         else if (a[11:8] == 4'h2) tag = $sformatf("R10 read %h", a);
         else tag = $sformatf("R2 read %h", a);
         rd(a, VEC[i][31:0], tag);
      end

      // R3 back-to-back requests keep order
      @(negedge clk);
      reg_addr = 12'h108; reg_rd_req = 1'b1;
      @(negedge clk);
      reg_addr = 12'h214;
      @(negedge clk);
      reg_rd_req = 1'b0;
      chk("R3 b2b first valid", {31'd0, reg_rd_valid}, 32'd1);
      chk("R3 b2b first data", reg_rd_data, 32'hDEAD_BEEF);
      @(negedge clk);
      chk("R3 b2b second valid", {31'd0, reg_rd_valid}, 32'd1);
      chk("R3 b2b second data", reg_rd_data, 32'h9999_AAAA);
      @(negedge clk);
      chk("R3 b2b end", {31'd0, reg_rd_valid}, 32'd0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule